// File: doc/BRIEF.md
# Symbol Timing Phase-Control Loop

This block is the loop filter and phase accumulator of a symbol clock recovery chain. Once per output symbol it receives a timing error, already limited to the range of a Q1.15 value. It updates a samples-per-symbol frequency estimate and a fractional sampling phase. The frequency estimate is kept inside a window placed symmetrically around a programmed nominal value. The new phase is then split into a whole number of input samples to advance and a fractional remainder. Only the remainder stays in the phase register. The advance count and the fraction feed the sample pointer and the coefficient selection of an interpolator placed upstream.

Phase and frequency are signed Q8.16 values. The two loop gains and the relative window width are unsigned Q0.16 values. A single write port loads the nominal rate, both gains and the window width. A separate restart strobe puts the loop back to its start point without changing any programmed value.

Top module: `sym_timing_loop`

## Requirements
- R1: After reset, out_valid is 0, the nominal rate and the frequency estimate are 0x020000 (2.0), the phase is 0, the frequency gain is 0x0200, the phase gain is 0x2000 and the window width is 0x0CCD.
- R2: out_valid goes high in the cycle after a cycle in which err_valid is high and neither restart nor a nominal-rate write is present. It stays low in every other cycle.
- R3: For each symbol the update runs in this order. First, the frequency estimate gains floor(err×kf/2^15), where err is the signed Q1.15 input and kf is the frequency gain. Second, the frequency estimate is clamped to the window. Third, the phase gains the clamped frequency plus floor(err×kp/2^15), where kp is the phase gain.
- R4: The new phase is split as follows. adv_count is bits [23:16] of the new phase, taken as a two's-complement floor. frac_phase is bits [15:0]. Only the fraction is kept in the phase register for the next symbol.
- R5: The window runs from omega−d to omega+d, where d = floor(omega×rel/2^16), omega is the nominal rate and rel is the window width.
- R6: cfg_sel picks the register for a write: 0 is the nominal rate, 1 is the frequency gain, 2 is the phase gain and 3 is the window width. The gains and the width take the low 16 bits of cfg_data. Each one can be written without changing the others, and a new value is used from the next symbol onward.
- R7: A write to the nominal rate stores cfg_data. It also loads the frequency estimate with that value, sets the phase to 0 and moves the window to the new rate.
- R8: A restart pulse loads the frequency estimate with the stored nominal rate and sets the phase to 0. It leaves the nominal rate, the gains and the width unchanged.
- R9: When restart or a nominal-rate write coincides with err_valid, the symbol is discarded. No out_valid follows, and the loop state is the reload state.
- R10: A write to the window width does not move the frequency estimate by itself. The new window applies when the next symbol updates the estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for a write |
| cfg_data | input | 24 | Write data (Q8.16 rate, or Q0.16 value in the low bits) |
| restart | input | 1 | Reload the loop state from the nominal rate |
| err_valid | input | 1 | Timing error present this cycle |
| err_in | input | 16 | Signed Q1.15 timing error |
| out_valid | output | 1 | Advance and fraction are valid |
| adv_count | output | 8 | Whole input samples to advance (two's complement) |
| frac_phase | output | 16 | Fractional sampling phase, Q0.16 |

## Verification
The first pattern is a run of zero errors at an integer rate and then at a fractional rate of 2.5. This separates the floor split, where the advance alternates 2 and 3, from the gain paths. A mixed run of positive, negative and full-scale errors with non-zero gains tests the arithmetic shifts and the order of the update steps. Saturating error runs drive the estimate against each edge of the window. A narrowed window after a zero-gain idle separates a clamp made at update time from one made at write time. Errors that arrive together with restart or a rate write show that the symbol is dropped and not processed.

// File: rtl/sym_timing_loop.sv
module sym_timing_loop #(
  parameter int INT_W      = 8,
  parameter int FRAC_W     = 16,
  parameter int ERR_W      = 16,
  parameter int GAIN_W     = 16,
  parameter int OMEGA_INIT = 'h020000,
  parameter int KF_INIT    = 'h0200,
  parameter int KP_INIT    = 'h2000,
  parameter int REL_INIT   = 'h0CCD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [INT_W+FRAC_W-1:0] cfg_data,
  input  logic                    restart,
  input  logic                    err_valid,
  input  logic [ERR_W-1:0]        err_in,
  output logic                    out_valid,
  output logic [INT_W-1:0]        adv_count,
  output logic [FRAC_W-1:0]       frac_phase
);
  localparam int PW  = INT_W + FRAC_W;
  localparam int EW  = PW + 2;
  localparam int PRW = ERR_W + GAIN_W + 1;
  localparam int SH  = ERR_W - 1 + GAIN_W - FRAC_W;
  localparam int LW  = PW + GAIN_W + 1;

  logic signed [PW-1:0] omega_r, freq_r, phase_r;
  logic [GAIN_W-1:0]    kf_r, kp_r, rel_r;

  wire omega_wr = cfg_we && (cfg_sel == 2'd0);
  wire reload   = omega_wr || restart;

  logic signed [PRW-1:0] err_x, prod_f, prod_p, sh_f, sh_p;
  assign err_x  = {{(PRW-ERR_W){err_in[ERR_W-1]}}, err_in};
  assign prod_f = err_x * $signed({{(PRW-GAIN_W){1'b0}}, kf_r});
  assign prod_p = err_x * $signed({{(PRW-GAIN_W){1'b0}}, kp_r});
  assign sh_f   = prod_f >>> SH;
  assign sh_p   = prod_p >>> SH;

  logic signed [LW-1:0] lim_p, lim_s;
  assign lim_p = $signed({{(LW-PW){omega_r[PW-1]}}, omega_r})
               * $signed({{(LW-GAIN_W){1'b0}}, rel_r});
  assign lim_s = lim_p >>> GAIN_W;

  logic signed [EW-1:0] omega_e, freq_e, phase_e, df, dp, delta;
  logic signed [EW-1:0] lim_lo, lim_hi, f1, fc, p1;
  assign omega_e = {{(EW-PW){omega_r[PW-1]}}, omega_r};
  assign freq_e  = {{(EW-PW){freq_r[PW-1]}}, freq_r};
  assign phase_e = {{(EW-PW){phase_r[PW-1]}}, phase_r};
  assign df      = sh_f[EW-1:0];
  assign dp      = sh_p[EW-1:0];
  assign delta   = lim_s[EW-1:0];
  assign lim_lo  = omega_e - delta;
  assign lim_hi  = omega_e + delta;
  assign f1      = freq_e + df;
  assign fc      = (f1 < lim_lo) ? lim_lo : (f1 > lim_hi) ? lim_hi : f1;
  assign p1      = phase_e + fc + dp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      omega_r    <= PW'(OMEGA_INIT);
      freq_r     <= PW'(OMEGA_INIT);
      phase_r    <= '0;
      kf_r       <= GAIN_W'(KF_INIT);
      kp_r       <= GAIN_W'(KP_INIT);
      rel_r      <= GAIN_W'(REL_INIT);
      out_valid  <= 1'b0;
      adv_count  <= '0;
      frac_phase <= '0;
    end else begin
      out_valid <= err_valid && !reload;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: omega_r <= cfg_data;
          2'd1: kf_r    <= cfg_data[GAIN_W-1:0];
          2'd2: kp_r    <= cfg_data[GAIN_W-1:0];
          default: rel_r <= cfg_data[GAIN_W-1:0];
        endcase
      end
      if (reload) begin
        freq_r  <= omega_wr ? cfg_data : omega_r;
        phase_r <= '0;
      end else if (err_valid) begin
        freq_r     <= fc[PW-1:0];
        phase_r    <= {{INT_W{1'b0}}, p1[FRAC_W-1:0]};
        adv_count  <= p1[PW-1:FRAC_W];
        frac_phase <= p1[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sym_timing_loop_chk.sv
module stl_checker #(
  parameter int PW     = 24,
  parameter int EW     = 26,
  parameter int GAIN_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [1:0]           cfg_sel,
  input logic [PW-1:0]        cfg_data,
  input logic                 restart,
  input logic                 err_valid,
  input logic                 out_valid,
  input logic signed [PW-1:0] omega_r,
  input logic signed [PW-1:0] freq_r,
  input logic signed [PW-1:0] phase_r,
  input logic [GAIN_W-1:0]    rel_r,
  input logic signed [EW-1:0] lim_lo,
  input logic signed [EW-1:0] lim_hi
);
  wire om_wr = cfg_we && (cfg_sel == 2'd0);

  AST_OUT_AFTER_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !restart && !om_wr |=> out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> !out_valid); // R2
  AST_DROP_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && (restart || om_wr) |=> !out_valid); // R9
  AST_OMEGA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    om_wr |=> (omega_r == $past(cfg_data)) && (freq_r == $past(cfg_data)) && (phase_r == '0)); // R7
  AST_RESTART_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restart && !om_wr |=> (freq_r == $past(omega_r)) && (phase_r == '0)); // R8
  AST_FREQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $stable(omega_r) && $stable(rel_r) |-> (freq_r >= lim_lo) && (freq_r <= lim_hi)); // R5
endmodule

bind sym_timing_loop stl_checker #(.PW(PW), .EW(EW), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
  .restart(restart), .err_valid(err_valid), .out_valid(out_valid),
  .omega_r(omega_r), .freq_r(freq_r), .phase_r(phase_r), .rel_r(rel_r),
  .lim_lo(lim_lo), .lim_hi(lim_hi)
);

// File: tb/tb_sym_timing_loop.sv
module tb_sym_timing_loop;
  logic        clk = 0, rst_n = 0, cfg_we = 0, restart = 0, err_valid = 0;
  logic [1:0]  cfg_sel = 0;
  logic [23:0] cfg_data = 0;
  logic [15:0] err_in = 0;
  logic        out_valid;
  logic [7:0]  adv_count;
  logic [15:0] frac_phase;
  int nchk = 0, nerr = 0;
  longint m_om, m_kf, m_kp, m_rel, m_freq, m_phase;

  always #5 clk = ~clk;

  sym_timing_loop dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .restart(restart), .err_valid(err_valid), .err_in(err_in),
    .out_valid(out_valid), .adv_count(adv_count), .frac_phase(frac_phase));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic m_reload();
    m_freq = m_om; m_phase = 0;
  endtask

  task automatic wr(input int sel, input longint d);
    @(negedge clk); cfg_we = 1; cfg_sel = 2'(sel); cfg_data = 24'(d);
    @(negedge clk); cfg_we = 0;
    case (sel)
      0: begin m_om = d; m_reload(); end
      1: m_kf = d; 2: m_kp = d; default: m_rel = d;
    endcase
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
    m_reload();
  endtask

  task automatic sym(input longint e, input string tag);
    longint f, lo, hi, p, ea, fa;
    @(negedge clk); err_valid = 1; err_in = 16'(e);
    @(negedge clk); err_valid = 0;
    f  = m_freq + ((e * m_kf) >>> 15);
    lo = m_om - ((m_om * m_rel) >>> 16);
    hi = m_om + ((m_om * m_rel) >>> 16);
    if (f < lo) f = lo;
    if (f > hi) f = hi;
    p  = m_phase + f + ((e * m_kp) >>> 15);
    ea = p >>> 16; fa = p & 64'hFFFF;
    m_freq = f; m_phase = fa;
    chk(out_valid === 1'b1, {tag, " R2 out_valid"}, longint'(out_valid), 1);
    chk(adv_count === 8'(ea), {tag, " adv"}, longint'(adv_count), ea & 8'hFF);
    chk(frac_phase === 16'(fa), {tag, " frac"}, longint'(frac_phase), fa);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    sym(0, "R1 first symbol");
    chk(adv_count === 8'd2 && frac_phase === 16'h0, "R1 R4 nominal 2.0",
        longint'({adv_count, frac_phase}), 'h020000);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R2 idle no valid", longint'(out_valid), 0);
    end
    sym(0, "R2 state held over idle");
  endtask

  task automatic t_fractional();
    wr(0, 'h028000);
    sym(0, "R7 R4 rate 2.5 a");
    chk(adv_count === 8'd2 && frac_phase === 16'h8000, "R4 split 2/0.5",
        longint'({adv_count, frac_phase}), 'h028000);
    sym(0, "R4 rate 2.5 b");
    chk(adv_count === 8'd3 && frac_phase === 16'h0, "R4 split 3/0",
        longint'({adv_count, frac_phase}), 'h030000);
    sym(0, "R4 rate 2.5 c");
  endtask

  task automatic t_tracking();
    wr(1, 'h0400); wr(2, 'h4000); wr(3, 'h2000);
    sym('h2000, "R3 R6 pos");
    sym(-'h1800, "R3 neg");
    sym('h7FFF, "R3 max");
    sym(-'h8000, "R3 min");
    sym('h0123, "R3 small");
    sym(-1, "R3 floor of -1");
  endtask

  task automatic t_clamp();
    wr(3, 'h1000); wr(1, 'hFFFF); wr(2, 0); wr(0, 'h020000);
    sym('h7FFF, "R5 clamp high");
    chk(adv_count === 8'd2 && frac_phase === 16'h2000, "R5 high edge 2.125",
        longint'({adv_count, frac_phase}), 'h022000);
    sym('h7FFF, "R5 held at high");
    do_restart();
    sym(-'h8000, "R8 R5 clamp low");
    chk(adv_count === 8'd1 && frac_phase === 16'hE000, "R5 low edge 1.875",
        longint'({adv_count, frac_phase}), 'h01E000);
  endtask

  task automatic t_rel_write();
    wr(1, 0);
    wr(3, 'h2000);
    sym(0, "R10 wider window keeps freq");
    chk(adv_count === 8'd2 && frac_phase === 16'hC000, "R10 freq still 1.875",
        longint'({adv_count, frac_phase}), 'h02C000);
    wr(3, 'h0800);
    sym(0, "R10 narrow window clamps");
    chk(adv_count === 8'd2 && frac_phase === 16'hB000, "R10 freq now 1.9375",
        longint'({adv_count, frac_phase}), 'h02B000);
  endtask

  task automatic t_priority();
    @(negedge clk); err_valid = 1; err_in = 16'h4000; restart = 1;
    @(negedge clk); err_valid = 0; restart = 0;
    m_reload();
    chk(out_valid === 1'b0, "R9 drop with restart", longint'(out_valid), 0);
    sym(0, "R9 R8 after restart");
    @(negedge clk); err_valid = 1; err_in = 16'h4000;
    cfg_we = 1; cfg_sel = 2'd0; cfg_data = 24'h030000;
    @(negedge clk); err_valid = 0; cfg_we = 0;
    m_om = 'h030000; m_reload();
    chk(out_valid === 1'b0, "R9 drop with rate write", longint'(out_valid), 0);
    sym(0, "R9 R7 after rate write");
    chk(adv_count === 8'd3 && frac_phase === 16'h0, "R7 rate 3.0",
        longint'({adv_count, frac_phase}), 'h030000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    m_om = 'h020000; m_kf = 'h0200; m_kp = 'h2000; m_rel = 'h0CCD;
    m_reload();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_idle();
    t_fractional();
    t_tracking();
    t_clamp();
    t_rel_write();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule